// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character into an asynchronous serial frame on a single transmit line. A producer offers a byte with a valid/ready handshake. The block takes it when it is free and sends a start bit at 0, then the data bits least significant first, then an optional parity bit, then the stop period at 1. Between frames the line rests at 1.

The frame format comes from a set of line-control inputs:

- a 2-bit word-length field
- a stop-length select
- parity enable
- an even/odd select
- a forced-parity select
- a break control

The block copies the format inputs, except break, when it takes a character. A format change made while a frame is on the line therefore applies only to later frames.

Timing comes from an external oversampling tick, a one-cycle enable pulse. Each bit lasts `OVS` ticks, so a half-bit stop is possible. The break control acts on the live input and overrides the line at once, whatever the frame state is.

Top module: `uart_frame_tx`

## Requirements
- R1: With no break, `tx` rests at 1 between frames. A frame starts with one bit at 0, followed by the data bits of `in_data`, least significant first. The number of data bits is set by `cfg_wlen`: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8.
- R2: Every start, data and parity bit lasts exactly `OVS` tick pulses. With `cfg_stop` at 0, the stop period is one bit at 1, `OVS` ticks long, for every word length.
- R3: With `cfg_stop` at 1 and `cfg_wlen` at 00, the stop period is held at 1 for `OVS*3/2` ticks.
- R4: With `cfg_stop` at 1 and `cfg_wlen` at 01, 10 or 11, the stop period is held at 1 for `2*OVS` ticks.
- R5: With `cfg_par_en` at 0, the stop period follows the last data bit directly. With `cfg_par_en` at 1, exactly one parity bit is placed between the last data bit and the stop period.
- R6: With parity enabled and `cfg_par_stick` at 0, `cfg_par_even` at 0 makes the count of ones in the data bits plus the parity bit odd. `cfg_par_even` at 1 makes that count even.
- R7: With parity enabled and `cfg_par_stick` at 1, the parity bit is 1 when `cfg_par_even` is 0 and 0 when it is 1, whatever the data.
- R8: While `cfg_break` is 1, `tx` is 0 from the next clock cycle on, whether the block is idle or sending. Clearing `cfg_break` releases the line on the next cycle, and the frame timing continues unaffected throughout.
- R9: The format inputs (`cfg_wlen`, `cfg_stop`, `cfg_par_en`, `cfg_par_even`, `cfg_par_stick`) and the data are captured on the accepting cycle. Changing them during a frame has no effect on that frame.
- R10: `in_ready` is 1 whenever the block is idle and 0 during a frame. The one exception is the cycle that carries the final tick of the stop period: there `in_ready` is 1, so a waiting character starts with no idle gap.
- R11: `busy` rises on the cycle after a character is accepted. It falls on the cycle after the final stop tick unless another character is accepted on that cycle.
- R12: After reset, `tx` is 1, `busy` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle oversample enable, `OVS` per bit |
| in_data | input | DATA_W | Character to send |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can take a character this cycle |
| cfg_wlen | input | 2 | Data bit count: 00=5, 01=6, 10=7, 11=8 |
| cfg_stop | input | 1 | Long stop period select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity select; with forced parity, 1 selects a 0 parity bit |
| cfg_par_stick | input | 1 | Forced parity select |
| cfg_break | input | 1 | Hold the line at 0 while set |
| tx | output | 1 | Serial line, registered |
| busy | output | 1 | Frame in progress, registered |

## Verification
The bench builds the block with `OVS` at 4 and drives a tick on every second clock. This keeps each frame under about a hundred cycles, so every word length, both stop lengths and all parity modes fit in one short run. With an even but small `OVS`, the 1.5-bit stop is exactly 6 ticks. That count differs from both the 4-tick and the 8-tick stop periods, so a wrong stop length shows up as a different sample count.

The bench records the line on every tick and compares the whole record with a frame built from the requirements. This covers the back-to-back start on the final stop tick, a format change in mid-frame, and break applied both while idle and while sending.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_t;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop_long;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } line_fmt_t;

endpackage

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  line_fmt_t         fmt,
  output logic              par_bit
);

  logic ones_odd;

  // XOR across the active data bits only (5 + wlen of them)
  always_comb begin
    ones_odd = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < 5 + int'(fmt.wlen)) ones_odd = ones_odd ^ data[i];
    end
  end

  always_comb begin
    if (fmt.par_stick) par_bit = ~fmt.par_even;   // mark when 0, space when 1
    else if (fmt.par_even) par_bit = ones_odd;    // total ones even
    else par_bit = ~ones_odd;                     // total ones odd
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  line_fmt_t         fmt,
  input  logic              par_bit,
  input  logic              brk,
  output logic              tx,
  output logic              busy,
  output logic              slot_free
);

  localparam int IW = $clog2(DATA_W);
  localparam int CW = $clog2(2 * OVS + 1);
  localparam logic [CW-1:0] LEN_BIT  = CW'(OVS);
  localparam logic [CW-1:0] LEN_1P5  = CW'(OVS + OVS / 2);
  localparam logic [CW-1:0] LEN_TWO  = CW'(2 * OVS);

  tx_state_t      state_q, state_n;
  logic [IW-1:0]  idx_q, idx_n;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  phase_len;
  logic [IW-1:0]  last_idx;
  logic           phase_end;
  logic           line_n;
  logic           tx_q, busy_q;

  assign last_idx = IW'(4) + IW'(fmt.wlen);

  always_comb begin
    phase_len = LEN_BIT;
    if (state_q == ST_STOP && fmt.stop_long)
      phase_len = (fmt.wlen == 2'b00) ? LEN_1P5 : LEN_TWO;
  end

  assign phase_end = tick && (state_q != ST_IDLE) && (cnt_q == phase_len - CW'(1));
  assign slot_free = (state_q == ST_IDLE) || (state_q == ST_STOP && phase_end);

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    unique case (state_q)
      ST_IDLE:  if (load) state_n = ST_START;
      ST_START: if (phase_end) begin
        state_n = ST_DATA;
        idx_n   = '0;
      end
      ST_DATA:  if (phase_end) begin
        if (idx_q == last_idx) state_n = fmt.par_en ? ST_PAR : ST_STOP;
        else idx_n = idx_q + IW'(1);
      end
      ST_PAR:   if (phase_end) state_n = ST_STOP;
      ST_STOP:  if (phase_end) state_n = load ? ST_START : ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_n)
      ST_START: line_n = 1'b0;
      ST_DATA:  line_n = data[idx_n];
      ST_PAR:   line_n = par_bit;
      default:  line_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      tx_q    <= 1'b1;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      if (phase_end || load) cnt_q <= '0;
      else if (tick && state_q != ST_IDLE) cnt_q <= cnt_q + CW'(1);
      tx_q    <= brk ? 1'b0 : line_n;
      busy_q  <= (state_n != ST_IDLE);
    end
  end

  assign tx   = tx_q;
  assign busy = busy_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_stop,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_par_stick,
  input  logic              cfg_break,
  output logic              tx,
  output logic              busy
);

  line_fmt_t         fmt_q;
  logic [DATA_W-1:0] data_q;
  logic              load;
  logic              slot_free;
  logic              par_bit;

  assign in_ready = slot_free;
  assign load     = in_valid && slot_free;

  // Frame format and character are frozen at acceptance
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q  <= '0;
      data_q <= '0;
    end else if (load) begin
      fmt_q  <= '{wlen: cfg_wlen, stop_long: cfg_stop, par_en: cfg_par_en,
                  par_even: cfg_par_even, par_stick: cfg_par_stick};
      data_q <= in_data;
    end
  end

  uart_tx_parity #(.DATA_W(DATA_W)) u_par (
    .data    (data_q),
    .fmt     (fmt_q),
    .par_bit (par_bit)
  );

  uart_tx_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (load),
    .data      (data_q),
    .fmt       (fmt_q),
    .par_bit   (par_bit),
    .brk       (cfg_break),
    .tx        (tx),
    .busy      (busy),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic cfg_break,
  input logic tx,
  input logic busy
);

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_break) |-> !tx); // R8

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(cfg_break)) |-> tx); // R1

  AST_START_SPACE: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !$past(cfg_break)) |-> !tx); // R1

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> in_ready); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy); // R11

endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .cfg_break (cfg_break),
  .tx        (tx),
  .busy      (busy)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 4;
  localparam int DATA_W     = 8;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        cfg_wlen = 2'b11;
  logic              cfg_stop = 1'b0;
  logic              cfg_par_en = 1'b0;
  logic              cfg_par_even = 1'b0;
  logic              cfg_par_stick = 1'b0;
  logic              cfg_break = 1'b0;
  logic              tx;
  logic              busy;

  int n_tests = 0;
  int n_fail  = 0;

  logic exp_s [0:511];
  int   exp_n;
  logic got_s [0:511];
  int   got_n;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // tick on every second clock
  always_ff @(posedge clk) begin
    if (rst) tick <= 1'b0;
    else     tick <= ~tick;
  end

  uart_frame_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_uart_frame_tx (
    .clk(clk), .rst(rst), .tick(tick), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .cfg_wlen(cfg_wlen), .cfg_stop(cfg_stop),
    .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_par_stick(cfg_par_stick), .cfg_break(cfg_break), .tx(tx), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic v, input int ticks);
    for (int i = 0; i < ticks; i++) begin
      exp_s[exp_n] = v;
      exp_n++;
    end
  endtask

  task automatic build_exp(input logic [7:0] d, input logic [1:0] wl, input logic st,
                           input logic pe, input logic pev, input logic pst);
    int   nb;
    int   ones;
    logic p;
    nb   = 5 + int'(wl);
    ones = 0;
    exp_n = 0;
    push(1'b0, OVS);
    for (int i = 0; i < nb; i++) begin
      push(d[i], OVS);
      if (d[i]) ones++;
    end
    if (pe) begin
      if (pst)      p = ~pev;
      else if (pev) p = (ones % 2) == 1;
      else          p = (ones % 2) == 0;
      push(p, OVS);
    end
    if (!st)           push(1'b1, OVS);
    else if (wl == 0)  push(1'b1, OVS + OVS / 2);
    else               push(1'b1, 2 * OVS);
  endtask

  task automatic set_cfg(input logic [1:0] wl, input logic st, input logic pe,
                         input logic pev, input logic pst);
    cfg_wlen = wl; cfg_stop = st; cfg_par_en = pe;
    cfg_par_even = pev; cfg_par_stick = pst;
  endtask

  // offer a character; returns just after the accepting edge
  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic capture();
    int guard;
    got_n = 0;
    guard = 0;
    forever begin
      @(negedge clk);
      if (!busy || guard > 2000) break;
      if (tick) begin
        got_s[got_n] = tx;
        got_n++;
      end
      guard++;
    end
  endtask

  task automatic compare(input string req, input string what);
    int bad;
    bad = -1;
    for (int i = 0; i < exp_n; i++)
      if (i < got_n && got_s[i] !== exp_s[i] && bad < 0) bad = i;
    chk(got_n == exp_n, req, {what, " tick count"}, got_n, exp_n);
    chk(bad < 0, req, {what, " first mismatching tick"}, bad, -1);
  endtask

  task automatic t_frame(input string req, input string what, input logic [7:0] d,
                         input logic [1:0] wl, input logic st, input logic pe,
                         input logic pev, input logic pst);
    set_cfg(wl, st, pe, pev, pst);
    build_exp(d, wl, st, pe, pev, pst);
    offer(d);
    capture();
    compare(req, what);
    chk(tx === 1'b1 && in_ready === 1'b1, req, "idle after frame", int'(tx), 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tx === 1'b1, "R12", "tx in reset", int'(tx), 1);
    chk(busy === 1'b0, "R12", "busy in reset", int'(busy), 0);
    chk(in_ready === 1'b1, "R12", "ready in reset", int'(in_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(tx === 1'b1 && busy === 1'b0, "R12", "idle after reset", int'(tx), 1);
  endtask

  task automatic t_cfg_latch();
    int saw_ready;
    saw_ready = 0;
    set_cfg(2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
    build_exp(8'hA5, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0);
    offer(8'hA5);
    // R9: change every format input and the data right after acceptance
    set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b1);
    in_data = 8'h00;
    got_n = 0;
    forever begin
      @(negedge clk);
      if (!busy || got_n > 400) break;
      if (in_ready && !(tick && got_n == exp_n - 1)) saw_ready++;
      if (tick) begin
        got_s[got_n] = tx;
        got_n++;
      end
    end
    compare("R9", "frame after mid-frame format change");
    chk(saw_ready == 0, "R10", "ready during frame", saw_ready, 0);
  endtask

  task automatic t_back_to_back();
    int gap;
    logic a_ok;
    gap = 0;
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    build_exp(8'h3C, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    offer(8'h3C);
    set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    in_data  = 8'h5A;
    in_valid = 1'b1;
    got_n = 0;
    forever begin
      @(negedge clk);
      if (!busy) gap++;
      if (tick) begin
        got_s[got_n] = tx;
        got_n++;
      end
      if (in_ready || got_n > 400) break;
    end
    compare("R10", "first frame up to ready");
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    if (!busy) gap++;
    chk(gap == 0, "R11", "idle cycles between frames", gap, 0);
    a_ok = (tx === 1'b0);
    chk(a_ok, "R10", "second start bit follows at once", int'(tx), 0);
    build_exp(8'h5A, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    // first sample of the second frame is taken below: re-capture from here
    got_n = 0;
    if (tick) begin
      got_s[0] = tx;
      got_n = 1;
    end
    forever begin
      @(negedge clk);
      if (!busy || got_n > 400) break;
      if (tick) begin
        got_s[got_n] = tx;
        got_n++;
      end
    end
    compare("R10", "second back-to-back frame");
  endtask

  task automatic t_break();
    int lows;
    // R8 while idle
    @(negedge clk);
    cfg_break = 1'b1;
    @(negedge clk);
    chk(tx === 1'b0, "R8", "break while idle", int'(tx), 0);
    repeat (5) @(negedge clk);
    chk(tx === 1'b0 && busy === 1'b0, "R8", "break held while idle", int'(tx), 0);
    cfg_break = 1'b0;
    @(negedge clk);
    chk(tx === 1'b1, "R8", "release after idle break", int'(tx), 1);
    // R8 during a frame
    set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    offer(8'hFF);
    repeat (12) @(negedge clk);
    cfg_break = 1'b1;
    @(negedge clk);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      if (tx === 1'b0) lows++;
      @(negedge clk);
    end
    chk(lows == 20, "R8", "cycles low under break in frame", lows, 20);
    chk(busy === 1'b1, "R8", "frame keeps running under break", int'(busy), 1);
    cfg_break = 1'b0;
    @(negedge clk);
    chk(tx === 1'b1, "R8", "release mid frame (data all ones)", int'(tx), 1);
    capture();
    chk(busy === 1'b0 && tx === 1'b1, "R8", "frame completes after break", int'(busy), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_frame("R1", "8-bit one stop", 8'h96, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    t_frame("R1", "5-bit", 8'hF3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    t_frame("R2", "6-bit one stop", 8'h2D, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    t_frame("R3", "5-bit 1.5 stop", 8'h15, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    t_frame("R4", "7-bit two stop", 8'h4B, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    t_frame("R4", "8-bit two stop parity", 8'hC1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    t_frame("R5", "7-bit with parity", 8'h7F, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
    t_frame("R6", "odd parity even ones", 8'h33, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    t_frame("R6", "even parity odd ones", 8'h07, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    t_frame("R6", "odd parity ignores unsent bit", 8'hE1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    t_frame("R7", "forced mark", 8'h00, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
    t_frame("R7", "forced space", 8'hFF, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1);
    t_cfg_latch();
    t_back_to_back();
    t_break();
    t_frame("R11", "frame after break", 8'h5A, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule